// File: doc/BRIEF.md
# LRU Translation Lookaside Buffer

This block is a small, fully associative cache of address translations placed in front of a page table walker. A lookup presents a 32-bit virtual address. The upper 20 bits, the virtual page number, are compared with the tag of every valid entry at once. Each entry maps one whole 4 KiB page. On a hit, the stored physical page number is joined to the untouched low 12 bits of the address. On a miss, the block asks the walker for the mapping, installs it, and then delivers the translation. Only one miss can be outstanding at a time. While the walk is in progress, the ready signal stays low and further lookups are held off.

A mapping that the walker reports as not resident in memory is still installed. Every lookup of that page, whether it fills or hits, reports a page fault instead of an address. Free entries are filled before any resident entry is displaced. Once the table is full, the entry that was used least recently is the one replaced. Both a hit and a fill make the touched entry the most recent. A flush input empties the whole table in one cycle.

Top module: `tlb_lru`

## Requirements
- R1: Reset state. After reset, `req_ready_o` is 1 and `rsp_valid_o` and `walk_req_o` are 0. The table is empty, so the first lookup of any page misses.
- R2: Hit. A lookup is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both high. When its page number matches a valid entry, `rsp_valid_o` and `rsp_hit_o` are 1 in the following cycle, no walk is requested, and `rsp_pa_o` equals {stored page, address bits 11:0}.
- R3: Miss. The cycle after an accepted lookup misses, `walk_req_o` rises and `walk_vpn_o` carries address bits 31:12. `walk_req_o` stays high until `walk_done_i` is seen, and `req_ready_o` stays low for that whole time.
- R4: Fill. On the edge where `walk_done_i` is high during a walk, the mapping is installed. In the next cycle `rsp_valid_o` is 1, `rsp_hit_o` is 0, `walk_req_o` is 0, and `rsp_pa_o` is {`walk_ppn_i`, the saved offset}. A later lookup of the same page hits.
- R5: While fewer than ENTRIES distinct pages have been filled since reset or flush, a fill never displaces a resident page, so ENTRIES distinct pages all hit afterwards.
- R6: With all entries valid, a fill replaces the entry least recently touched, where both hits and fills count as touches.
- R7: When `walk_on_disk_i` is 1 at the fill, the entry is still installed. That response, and every later hit on the page, has `rsp_fault_o` = 1 and `rsp_pa_o` = 0, and no new walk is requested.
- R8: A cycle with `flush_i` high forces `req_ready_o` low and invalidates every entry, so every page misses on its next lookup.
- R9: When `flush_i` and a fill fall on the same edge, the flush is applied first. The newly filled page is then the only valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Lookup can be accepted this cycle |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_hit_o | output | 1 | Result came from a resident entry (1) or a walk (0) |
| rsp_fault_o | output | 1 | Page is not resident in memory |
| rsp_pa_o | output | 28 | Physical address (0 on fault) |
| walk_req_o | output | 1 | Walk request, held until done |
| walk_vpn_o | output | 20 | Page number to walk |
| walk_done_i | input | 1 | Walker result valid |
| walk_ppn_i | input | 16 | Physical page number from walker |
| walk_on_disk_i | input | 1 | Walked page is not resident |

## Verification
A flush and the completion of a walk can land on the same clock edge. In that case the table must be cleared and then take the new entry, and the new entry must also be reset to most recent in the use order. The bench provokes this by having its walker model raise `flush_i` together with `walk_done_i` during one particular miss. It then judges the outcome purely at the ports: the freshly filled page must hit, and a page that was resident before must miss and request a walk. A software model of the use order predicts hit or miss for every lookup, including evictions that follow a mix of hits and fills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } tlb_state_e;
endpackage

// File: rtl/tlb_cam.sv
// Entry store with parallel tag compare and free-slot search.
module tlb_cam #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             wr_disk_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [PPN_W-1:0] hit_ppn_o,
  output logic             hit_disk_o,
  output logic             free_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic [ENTRIES-1:0] valid_o
);
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ENTRIES-1:0] disk_q;
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;

  // Payload arrays carry no reset; only the valid bits do.
  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_vpn_i;
      ppn_q[wr_idx_i]  <= wr_ppn_i;
      disk_q[wr_idx_i] <= wr_disk_i;
    end
  end

  // Flush is applied first, so a same-edge write survives it.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (flush_i) valid_q <= '0;
      if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn_i);
  end

  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i])    hit_idx_o  = IDX_W'(i);
      if (!valid_q[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign hit_o      = |match;
  assign free_o     = ~&valid_q;
  assign hit_ppn_o  = ppn_q[hit_idx_o];
  assign hit_disk_o = disk_q[hit_idx_o];
  assign valid_o    = valid_q;
endmodule

// File: rtl/tlb_lru_order.sv
// True LRU by per-entry age ranks; rank ENTRIES-1 is the oldest.
module tlb_lru_order #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] oldest_idx_o
);
  logic [IDX_W-1:0] age_q   [ENTRIES];
  logic [IDX_W-1:0] age_base[ENTRIES];
  logic [IDX_W-1:0] age_nxt [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      age_base[i] = flush_i ? IDX_W'(i) : age_q[i];
    touched_age = age_base[touch_idx_i];
    for (int i = 0; i < ENTRIES; i++) begin
      age_nxt[i] = age_base[i];
      if (touch_i) begin
        if (IDX_W'(i) == touch_idx_i)       age_nxt[i] = '0;
        else if (age_base[i] < touched_age) age_nxt[i] = age_base[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rst) age_q[i] <= IDX_W'(i);
      else     age_q[i] <= age_nxt[i];
    end
  end

  always_comb begin
    oldest_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == IDX_W'(ENTRIES - 1)) oldest_idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 16,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  input  logic             walk_done_i,
  input  logic [PPN_W-1:0] walk_ppn_i,
  input  logic             walk_on_disk_i
);
  import tlb_pkg::*;

  tlb_state_e         state_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic               accept, lk_hit, fill, lk_disk, cam_free;
  logic [IDX_W-1:0]   hit_idx, free_idx, oldest_idx, victim_idx, touch_idx;
  logic [PPN_W-1:0]   lk_ppn;
  logic [ENTRIES-1:0] valid_vec;

  assign req_ready_o = (state_q == ST_IDLE) && !flush_i;
  assign accept      = req_valid_i && req_ready_o;
  assign fill        = (state_q == ST_WALK) && walk_done_i;
  assign victim_idx  = cam_free ? free_idx : oldest_idx;
  assign touch_idx   = fill ? victim_idx : hit_idx;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (flush_i),
    .lk_vpn_i   (req_va_i[VA_W-1:OFF_W]),
    .wr_en_i    (fill),
    .wr_idx_i   (victim_idx),
    .wr_vpn_i   (vpn_q),
    .wr_ppn_i   (walk_ppn_i),
    .wr_disk_i  (walk_on_disk_i),
    .hit_o      (lk_hit),
    .hit_idx_o  (hit_idx),
    .hit_ppn_o  (lk_ppn),
    .hit_disk_o (lk_disk),
    .free_o     (cam_free),
    .free_idx_o (free_idx),
    .valid_o    (valid_vec)
  );

  tlb_lru_order #(.ENTRIES(ENTRIES)) u_lru (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .touch_i      (fill || (accept && lk_hit)),
    .touch_idx_i  (touch_idx),
    .oldest_idx_o (oldest_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      walk_req_o <= 1'b0;
      vpn_q      <= '0;
      off_q      <= '0;
    end else if (accept && !lk_hit) begin
      state_q    <= ST_WALK;
      walk_req_o <= 1'b1;
      vpn_q      <= req_va_i[VA_W-1:OFF_W];
      off_q      <= req_va_i[OFF_W-1:0];
    end else if (fill) begin
      state_q    <= ST_IDLE;
      walk_req_o <= 1'b0;
    end
  end

  assign walk_vpn_o = vpn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_pa_o    <= '0;
    end else begin
      rsp_valid_o <= (accept && lk_hit) || fill;
      if (accept && lk_hit) begin
        rsp_hit_o   <= 1'b1;
        rsp_fault_o <= lk_disk;
        rsp_pa_o    <= lk_disk ? '0 : {lk_ppn, req_va_i[OFF_W-1:0]};
      end else if (fill) begin
        rsp_hit_o   <= 1'b0;
        rsp_fault_o <= walk_on_disk_i;
        rsp_pa_o    <= walk_on_disk_i ? '0 : {walk_ppn_i, off_q};
      end
    end
  end
endmodule

// File: rtl/tlb_lru_chk.sv
module tlb_lru_chk #(
  parameter int ENTRIES = 4,
  parameter int PA_W    = 28
) (
  input logic               clk,
  input logic               rst,
  input logic               flush_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic               rsp_fault_o,
  input logic [PA_W-1:0]    rsp_pa_o,
  input logic               walk_req_o,
  input logic               walk_done_i,
  input logic               walk_on_disk_i,
  input logic [ENTRIES-1:0] valid_vec
);
  p_accept_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_ready_o |=> rsp_valid_o ^ walk_req_o);

  p_stall_walk_r3: assert property (@(posedge clk) disable iff (rst)
    walk_req_o |-> !req_ready_o);

  p_walk_hold_r3: assert property (@(posedge clk) disable iff (rst)
    walk_req_o && !walk_done_i |=> walk_req_o);

  p_fill_resp_r4: assert property (@(posedge clk) disable iff (rst)
    walk_req_o && walk_done_i |=> rsp_valid_o && !rsp_hit_o && !walk_req_o);

  p_disk_fault_r7: assert property (@(posedge clk) disable iff (rst)
    walk_req_o && walk_done_i && walk_on_disk_i |=> rsp_fault_o && (rsp_pa_o == '0));

  p_flush_stall_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |-> !req_ready_o);

  p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i && !(walk_req_o && walk_done_i) |=> valid_vec == '0);

  p_flush_fill_r9: assert property (@(posedge clk) disable iff (rst)
    flush_i && walk_req_o && walk_done_i |=> $countones(valid_vec) == 1);
endmodule

bind tlb_lru tlb_lru_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .flush_i        (flush_i),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_hit_o      (rsp_hit_o),
  .rsp_fault_o    (rsp_fault_o),
  .rsp_pa_o       (rsp_pa_o),
  .walk_req_o     (walk_req_o),
  .walk_done_i    (walk_done_i),
  .walk_on_disk_i (walk_on_disk_i),
  .valid_vec      (valid_vec)
);

// File: tb/tb_tlb_lru.sv
module tb_tlb_lru;
  localparam int ENT = 4;
  localparam int VPN_W = 20, OFF_W = 12, PPN_W = 16;
  localparam int PA_W = PPN_W + OFF_W;

  typedef struct packed {
    logic [PA_W-1:0] pa;
    logic            fault;
    logic            hit;
  } exp_t;

  logic clk = 0, rst = 1;
  logic flush_a = 0, flush_b = 0;
  logic req_valid = 0;
  logic [VPN_W+OFF_W-1:0] req_va = '0;
  logic walk_done = 0, walk_disk = 0;
  logic [PPN_W-1:0] walk_ppn = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, walk_req;
  logic [PA_W-1:0] rsp_pa;
  logic [VPN_W-1:0] walk_vpn;

  int checks = 0, errors = 0;
  bit done = 0;
  bit flush_with_fill = 0;
  logic [VPN_W-1:0] cur_vpn;
  exp_t exp_q[$];
  string tag_q[$];
  logic [VPN_W-1:0] mdl[$];  // most recent first

  always #5 clk = ~clk;

  tlb_lru #(.ENTRIES(ENT)) dut (
    .clk(clk), .rst(rst), .flush_i(flush_a | flush_b),
    .req_valid_i(req_valid), .req_va_i(req_va), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault),
    .rsp_pa_o(rsp_pa), .walk_req_o(walk_req), .walk_vpn_o(walk_vpn),
    .walk_done_i(walk_done), .walk_ppn_i(walk_ppn), .walk_on_disk_i(walk_disk)
  );

  function automatic logic [PPN_W-1:0] pt_ppn(logic [VPN_W-1:0] v);
    return v[15:0] ^ 16'h0A5C;
  endfunction
  function automatic logic pt_disk(logic [VPN_W-1:0] v);
    return (v == '0) || (v[7:0] == 8'hD0);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: predicts outcome from the LRU model, then issues the lookup.
  task automatic lookup(logic [VPN_W-1:0] vpn, logic [OFF_W-1:0] off, string req);
    exp_t e;
    int pos = -1;
    for (int i = 0; i < mdl.size(); i++) if (mdl[i] == vpn) pos = i;
    e.hit = (pos >= 0);
    if (pos >= 0) mdl.delete(pos);
    else if (flush_with_fill) mdl.delete();
    mdl.push_front(vpn);
    if (mdl.size() > ENT) void'(mdl.pop_back());
    e.fault = pt_disk(vpn);
    e.pa = e.fault ? '0 : {pt_ppn(vpn), off};
    exp_q.push_back(e);
    tag_q.push_back(req);
    cur_vpn = vpn;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1;
    req_va = {vpn, off};
    @(negedge clk);
    req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic flush_all();
    @(negedge clk);
    flush_a = 1;
    #1 chk("R8 ready low in flush", 64'(req_ready), 64'd0);
    @(negedge clk);
    flush_a = 0;
    mdl.delete();
  endtask

  // Monitor: pops the scoreboard on every response.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected response pa=%h", rsp_pa);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {35'd0, rsp_pa, rsp_fault, rsp_hit}, {35'd0, e.pa, e.fault, e.hit});
      end
    end
  end

  // Walker model with a varying latency.
  initial begin
    int nwalk = 0;
    forever begin
      @(negedge clk);
      if (!rst && walk_req) begin
        chk("R3 walk vpn", 64'(walk_vpn), 64'(cur_vpn));
        nwalk++;
        for (int k = 0; k < (nwalk % 3) + 1; k++) begin
          chk("R3 stall during walk", {62'd0, req_ready, walk_req}, 64'd1);
          @(negedge clk);
        end
        walk_done = 1;
        walk_ppn  = pt_ppn(walk_vpn);
        walk_disk = pt_disk(walk_vpn);
        flush_b   = flush_with_fill;
        @(negedge clk);
        walk_done = 0;
        flush_b   = 0;
        chk("R4 walk request dropped", 64'(walk_req), 64'd0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 no response", 64'(rsp_valid), 64'd0);
    chk("R1 no walk", 64'(walk_req), 64'd0);

    lookup(20'h00003, 12'h204, "R1 first lookup misses");
    lookup(20'h00005, 12'h120, "R4 fill");
    lookup(20'h00004, 12'h200, "R4 fill");
    lookup(20'h12345, 12'hFFF, "R5 fill last free entry");
    lookup(20'h00003, 12'h208, "R5 resident hit");
    lookup(20'h00005, 12'h000, "R2 hit offset zero");
    lookup(20'h00004, 12'hABC, "R2 hit");
    lookup(20'h12345, 12'h001, "R5 resident hit");

    lookup(20'h00003, 12'h010, "R6 refresh by hit");
    lookup(20'hABCDE, 12'h3C3, "R6 evict LRU");
    lookup(20'h00005, 12'h044, "R6 evicted page misses");
    lookup(20'h00003, 12'h055, "R6 refreshed page kept");
    lookup(20'h00004, 12'h066, "R6 evict LRU");
    lookup(20'hABCDE, 12'h077, "R6 recent fill kept");

    lookup(20'h00000, 12'h860, "R7 disk fill");
    lookup(20'h00000, 12'h861, "R7 disk hit");
    lookup(20'h7F0D0, 12'h100, "R7 disk fill");

    flush_all();
    lookup(20'h00003, 12'h222, "R8 miss after flush");
    lookup(20'h00005, 12'h333, "R8 miss after flush");

    flush_with_fill = 1;
    lookup(20'h00006, 12'h444, "R9 fill with flush");
    flush_with_fill = 0;
    lookup(20'h00006, 12'h445, "R9 filled page hits");
    lookup(20'h00003, 12'h446, "R9 old page gone");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule